// File: doc/BRIEF.md
# Posted Interrupt Coalescing Unit

This block turns message-signalled interrupt writes into pending bits in a 256-entry request bitmap, one bit per vector. It does not signal the CPU once per message. A single notification toward the CPU goes out only when no earlier notification is still outstanding. Every posted vector shares that one programmable notification vector, so a burst of interrupts to one CPU collapses into one wake-up.

The consumer reads the bitmap through a 64-bit exchange port, one of four words at a time. Each exchange returns the selected word and clears it in the same operation. When the consumer has drained the bitmap it issues a clear-flag command, which re-arms notification. Only that command can re-arm it: hardware never clears the outstanding flag by itself. A suppress input holds back notifications at run time, while posting into the bitmap carries on.

Top module: `pic_coalesce_top`

## Requirements
- R1: After reset the bitmap is empty, `flag_out` is 0, `notify_valid` is 0 and `notify_vector` is 0.
- R2: A write is accepted as an interrupt only when `wr_valid` is 1 and `wr_addr[31:20]` equals 12'hFEE. Any other write sets no bit, causes no notification and leaves the flag unchanged.
- R3: An accepted write with vector v sets bitmap bit v, which sits in word v/64 at bit position v%64. The bit stays set until an exchange of that word clears it.
- R4: When the flag is clear and suppress is 0, an accepted write causes the following events at the next clock edge. `notify_valid` rises for exactly one cycle, unless a clear-flag command re-fires it. `flag_out` is set.
- R5: While `flag_out` is 1 and no clear-flag command is given, accepted writes only set bitmap bits and cause no notification.
- R6: While `xchg_req` is 1, `xchg_data` shows the current contents of word `xchg_word` in the same cycle, and that word is cleared at the clock edge.
- R7: If an accepted write targets the word being exchanged in the same cycle, the new bit is absent from the returned data and is present in the bitmap after the exchange.
- R8: `flag_clr` clears the flag at the clock edge. If the bitmap after that edge is non-empty, a new notification is issued at the same edge, and the flag stays set.
- R9: While `suppress` is 1, no notification is issued and posting continues. Once `suppress` returns to 0 with the flag clear and the bitmap non-empty, a notification is issued at the next edge.
- R10: `notify_vector` carries the value that `notify_vec_cfg` had in the cycle the notification was decided. This holds for every posted vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request strobe |
| wr_addr | input | 32 | Write address; decoded for the interrupt window |
| wr_vector | input | 8 | Interrupt vector carried by the write |
| xchg_req | input | 1 | Exchange (read-and-clear) request |
| xchg_word | input | 2 | Bitmap word selected for exchange |
| xchg_data | output | 64 | Contents of the selected word before the clear |
| flag_clr | input | 1 | Command that clears the outstanding flag |
| suppress | input | 1 | Holds back notifications while 1 |
| notify_vec_cfg | input | 8 | Programmed notification vector |
| notify_valid | output | 1 | One-cycle notification pulse to the CPU |
| notify_vector | output | 8 | Vector sent with the notification |
| flag_out | output | 1 | Outstanding-notification flag |

## Verification
The assertions check several rules on every cycle. A notification appears only when the flag was free, and never while suppress was set. It carries the configured vector and always leaves the flag set. The flag drops only after a clear-flag command, and an accepted vector is present in the bitmap on the next cycle. An idle cycle with an empty bitmap never produces a notification.

The bench scenarios cover behaviour that needs ordering over several cycles. One is bursts that collapse into a single notification. Another is out-of-window writes that leave the bitmap unchanged, seen through later exchanges. The bench also covers a write that lands in the word being exchanged in the same cycle, a re-arm with work still pending, and the release of suppress.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned WIN_W    = 12;
  localparam logic [WIN_W-1:0] WIN_BASE = 12'hFEE;

  // Interrupt window decode: upper address bits select the message window.
  function automatic logic in_msi_window(input logic [ADDR_W-1:0] addr);
    return addr[ADDR_W-1 -: WIN_W] == WIN_BASE;
  endfunction
endpackage

// File: rtl/pic_msi_decode.sv
module pic_msi_decode #(
  parameter int unsigned VEC_W = 8
) (
  input  logic                      wr_valid,
  input  logic [pic_pkg::ADDR_W-1:0] wr_addr,
  input  logic [VEC_W-1:0]          wr_vector,
  output logic                      accept,
  output logic [VEC_W-1:0]          accept_vec
);
  assign accept     = wr_valid && pic_pkg::in_msi_window(wr_addr);
  assign accept_vec = wr_vector;
endmodule

// File: rtl/pic_pend_bitmap.sv
module pic_pend_bitmap #(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned WORD_W = 64,
  localparam int unsigned NVEC   = 1 << VEC_W,
  localparam int unsigned NWORDS = NVEC / WORD_W,
  localparam int unsigned WSEL_W = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [VEC_W-1:0]  set_vec,
  input  logic              xchg_req,
  input  logic [WSEL_W-1:0] xchg_word,
  output logic [WORD_W-1:0] xchg_data,
  output logic [NVEC-1:0]   pend_bits,
  output logic              pend_next_any
);
  function automatic logic [NVEC-1:0] vec_onehot(input logic [VEC_W-1:0] v);
    logic [NVEC-1:0] m;
    m = '0;
    m[v] = 1'b1;
    return m;
  endfunction

  logic [NVEC-1:0] pend_q;
  logic [NVEC-1:0] clr_mask;
  logic [NVEC-1:0] set_mask;
  logic [NVEC-1:0] pend_d;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign clr_mask[w*WORD_W +: WORD_W] =
      {WORD_W{xchg_req && (xchg_word == WSEL_W'(w))}};
  end

  assign set_mask      = set_en ? vec_onehot(set_vec) : '0;
  // Set after clear: a same-cycle write survives the exchange.
  assign pend_d        = (pend_q & ~clr_mask) | set_mask;
  assign pend_next_any = |pend_d;
  assign xchg_data     = pend_q[xchg_word*WORD_W +: WORD_W];
  assign pend_bits     = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/pic_notify_ctrl.sv
module pic_notify_ctrl #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_next_any,
  input  logic             flag_clr,
  input  logic             suppress,
  input  logic [VEC_W-1:0] notify_vec_cfg,
  output logic             fire,
  output logic             flag_q,
  output logic             notify_valid,
  output logic [VEC_W-1:0] notify_vector
);
  logic flag_free;

  assign flag_free = !flag_q || flag_clr;
  assign fire      = flag_free && !suppress && pend_next_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q        <= 1'b0;
      notify_valid  <= 1'b0;
      notify_vector <= '0;
    end else begin
      notify_valid <= fire;
      if (fire) begin
        flag_q        <= 1'b1;
        notify_vector <= notify_vec_cfg;
      end else if (flag_clr) begin
        flag_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pic_coalesce_top.sv
module pic_coalesce_top #(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned WORD_W = 64,
  localparam int unsigned NVEC   = 1 << VEC_W,
  localparam int unsigned NWORDS = NVEC / WORD_W,
  localparam int unsigned WSEL_W = $clog2(NWORDS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  input  logic [pic_pkg::ADDR_W-1:0] wr_addr,
  input  logic [VEC_W-1:0]           wr_vector,
  input  logic                       xchg_req,
  input  logic [WSEL_W-1:0]          xchg_word,
  output logic [WORD_W-1:0]          xchg_data,
  input  logic                       flag_clr,
  input  logic                       suppress,
  input  logic [VEC_W-1:0]           notify_vec_cfg,
  output logic                       notify_valid,
  output logic [VEC_W-1:0]           notify_vector,
  output logic                       flag_out
);
  logic             wr_accept;
  logic [VEC_W-1:0] accept_vec;
  logic [NVEC-1:0]  pend_bits;
  logic             pend_next_any;
  logic             pend_empty;
  logic             fire;

  pic_msi_decode #(.VEC_W(VEC_W)) u_decode (
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_vector  (wr_vector),
    .accept     (wr_accept),
    .accept_vec (accept_vec)
  );

  pic_pend_bitmap #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_bitmap (
    .clk           (clk),
    .rst_n         (rst_n),
    .set_en        (wr_accept),
    .set_vec       (accept_vec),
    .xchg_req      (xchg_req),
    .xchg_word     (xchg_word),
    .xchg_data     (xchg_data),
    .pend_bits     (pend_bits),
    .pend_next_any (pend_next_any)
  );

  pic_notify_ctrl #(.VEC_W(VEC_W)) u_notify (
    .clk            (clk),
    .rst_n          (rst_n),
    .pend_next_any  (pend_next_any),
    .flag_clr       (flag_clr),
    .suppress       (suppress),
    .notify_vec_cfg (notify_vec_cfg),
    .fire           (fire),
    .flag_q         (flag_out),
    .notify_valid   (notify_valid),
    .notify_vector  (notify_vector)
  );

  assign pend_empty = ~|pend_bits;
endmodule

// File: rtl/pic_coalesce_chk.sv
module pic_coalesce_chk #(
  parameter int unsigned VEC_W = 8,
  localparam int unsigned NVEC = 1 << VEC_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_accept,
  input logic [VEC_W-1:0] wr_vector,
  input logic [NVEC-1:0]  pend_bits,
  input logic             pend_empty,
  input logic             flag_clr,
  input logic             suppress,
  input logic [VEC_W-1:0] notify_vec_cfg,
  input logic             notify_valid,
  input logic [VEC_W-1:0] notify_vector,
  input logic             flag_out
);
  AST_NOTIFY_NEEDS_FREE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> (!$past(flag_out) || $past(flag_clr))); // R5
  AST_NOTIFY_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> flag_out); // R4
  AST_SUPPRESS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(suppress) |-> !notify_valid); // R9
  AST_NOTIFY_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> notify_vector == $past(notify_vec_cfg)); // R10
  AST_FLAG_SW_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_out && !flag_clr) |=> flag_out); // R8
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (notify_valid && !flag_clr) |=> !notify_valid); // R4
  AST_BIT_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_accept) |-> pend_bits[$past(wr_vector)]); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_accept) && $past(pend_empty)) |-> !notify_valid); // R2
endmodule

bind pic_coalesce_top pic_coalesce_chk #(.VEC_W(VEC_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_accept      (wr_accept),
  .wr_vector      (wr_vector),
  .pend_bits      (pend_bits),
  .pend_empty     (pend_empty),
  .flag_clr       (flag_clr),
  .suppress       (suppress),
  .notify_vec_cfg (notify_vec_cfg),
  .notify_valid   (notify_valid),
  .notify_vector  (notify_vector),
  .flag_out       (flag_out)
);

// File: tb/test_pic_coalesce_top.sv
module test_pic_coalesce_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [7:0]  wr_vector = '0;
  logic        xchg_req = 1'b0;
  logic [1:0]  xchg_word = '0;
  logic [63:0] xchg_data;
  logic        flag_clr = 1'b0;
  logic        suppress = 1'b0;
  logic [7:0]  notify_vec_cfg = 8'hEC;
  logic        notify_valid;
  logic [7:0]  notify_vector;
  logic        flag_out;

  int checks = 0;
  int fails  = 0;
  logic [255:0] m_pend = '0;
  logic         m_flag = 1'b0;
  logic [7:0]   expq[$];
  logic         running = 1'b0;

  always #2 clk = ~clk;

  pic_coalesce_top i_pic_coalesce_top (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_vector(wr_vector), .xchg_req(xchg_req), .xchg_word(xchg_word),
    .xchg_data(xchg_data), .flag_clr(flag_clr), .suppress(suppress),
    .notify_vec_cfg(notify_vec_cfg), .notify_valid(notify_valid),
    .notify_vector(notify_vector), .flag_out(flag_out)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: scoreboard pops one expected notification per observed pulse.
  always @(negedge clk) begin
    if (running) begin
      if (notify_valid) begin
        if (expq.size() == 0) check("R5 unexpected notify", 64'd1, 64'd0);
        else check("R10 notify vector", 64'(notify_vector), 64'(expq.pop_front()));
      end else if (expq.size() != 0) begin
        check("R4 missing notify", 64'd0, 64'd1);
        void'(expq.pop_front());
      end
    end
  end

  // Driver: one cycle of stimulus; updates the reference model and the queue.
  task automatic step(input logic wv, input logic [31:0] a, input logic [7:0] v,
                      input logic xr, input logic [1:0] xw,
                      input logic clr, input logic sup, input string req);
    logic [255:0] nxt;
    logic fire;
    @(negedge clk);
    #1;
    wr_valid = wv; wr_addr = a; wr_vector = v;
    xchg_req = xr; xchg_word = xw; flag_clr = clr; suppress = sup;
    #1;
    nxt = m_pend;
    if (xr) begin
      check({req, " xchg data"}, xchg_data, m_pend[xw*64 +: 64]);
      nxt[xw*64 +: 64] = '0;
    end
    if (wv && a[31:20] == 12'hFEE) nxt[v] = 1'b1;
    fire = (!m_flag || clr) && !sup && (nxt != '0);
    if (fire) begin
      expq.push_back(notify_vec_cfg);
      m_flag = 1'b1;
    end else if (clr) begin
      m_flag = 1'b0;
    end
    m_pend = nxt;
  endtask

  task automatic idle(input logic sup);
    step(1'b0, 32'h0, 8'h0, 1'b0, 2'd0, 1'b0, sup, "idle");
  endtask

  task automatic post(input logic [7:0] v, input string req);
    step(1'b1, 32'hFEE0_1000, v, 1'b0, 2'd0, 1'b0, 1'b0, req);
  endtask

  task automatic drain(input string req);
    for (int w = 0; w < 4; w++)
      step(1'b0, 32'h0, 8'h0, 1'b1, 2'(w), 1'b0, 1'b0, req);
  endtask

  task automatic flag_chk(input string req);
    @(negedge clk);
    #1;
    check(req, 64'(flag_out), 64'(m_flag));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 notify_valid", 64'(notify_valid), 64'd0);
    check("R1 flag", 64'(flag_out), 64'd0);
    check("R1 vector", 64'(notify_vector), 64'd0);
    running = 1'b1;
    drain("R1 empty bitmap");

    post(8'h31, "R4 first post");
    idle(1'b0);
    flag_chk("R4 flag set");

    post(8'h40, "R5 burst");
    post(8'hFF, "R5 burst");
    post(8'h05, "R5 burst");
    step(1'b1, 32'hFED0_0000, 8'h10, 1'b0, 2'd0, 1'b0, 1'b0, "R2 outside window");
    step(1'b1, 32'h7EE0_0000, 8'h11, 1'b0, 2'd0, 1'b0, 1'b0, "R2 outside window");
    idle(1'b0);
    drain("R3 R6 drain");
    drain("R6 after clear");

    step(1'b0, 32'h0, 8'h0, 1'b0, 2'd0, 1'b1, 1'b0, "R8 clear empty");
    idle(1'b0);
    flag_chk("R8 flag cleared");

    step(1'b1, 32'hFEE0_0000, 8'h10, 1'b0, 2'd0, 1'b0, 1'b0, "R2 boundary accept");
    step(1'b0, 32'h0, 8'h0, 1'b1, 2'd0, 1'b0, 1'b0, "R2 bit check");

    post(8'h41, "R7 setup");
    step(1'b1, 32'hFEE0_0004, 8'h42, 1'b1, 2'd1, 1'b0, 1'b0, "R7 same-cycle");
    step(1'b0, 32'h0, 8'h0, 1'b1, 2'd1, 1'b0, 1'b0, "R7 survived");

    post(8'h80, "R8 pending");
    notify_vec_cfg = 8'h22;
    step(1'b0, 32'h0, 8'h0, 1'b0, 2'd0, 1'b1, 1'b0, "R8 clear with pending");
    idle(1'b0);
    flag_chk("R8 flag re-set");
    drain("R8 drain");
    step(1'b0, 32'h0, 8'h0, 1'b0, 2'd0, 1'b1, 1'b0, "R8 re-arm");

    step(1'b1, 32'hFEE0_0000, 8'hC3, 1'b0, 2'd0, 1'b0, 1'b1, "R9 suppressed post");
    idle(1'b1);
    idle(1'b1);
    flag_chk("R9 flag stays clear");
    idle(1'b0);
    idle(1'b0);
    flag_chk("R9 flag after release");
    drain("R9 posting continued");
    repeat (3) idle(1'b0);

    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule